// File: doc/BRIEF.md
# Hop-Limited Echo Traversal Node

This block is the control engine of one non-root vertex in a graph that is searched breadth-first by iterative deepening. Neighbour vertices exchange two message kinds over valid/ready channels, one pair of channels in each direction per neighbour port. A request carries a round tag, which is the depth the root chose for this pass, and a hop budget that shrinks by one on every hop. An acknowledge carries a count of vertices that were reached for the first time.

The first request the node sees in a round picks its parent port. If budget remains, the node fans the request out to every other port with the budget reduced by one. It then collects one acknowledge from each of those ports and sends their sum, plus one if this is the first round that ever reached it, back to the parent. A request whose budget is already zero gets an immediate reply. A repeat request in a round the node has already joined gets an immediate reply with count zero. Arrival order across ports is never assumed, so a request on a long path may arrive before one on a short path.

Every channel follows the usual rules for valid and ready. A transfer happens on a rising edge where both are high. Once valid is raised, it and its payload stay unchanged until that transfer. The node's inbound ready signals may depend on the matching valid. Each outbound acknowledge port holds one message. While that slot is full, the node refuses further requests from that port, which pushes back on the sender.

Top module: `trav_node`

## Requirements
- R1: While reset is high on a clock edge, all outbound valid signals go low. The discovered flag, the round membership and the outstanding-acknowledge set are cleared, so the next request of any tag opens a new round.
- R2: A request opens a new round when the node is in no round or when its tag differs from the current tag. If its hop budget is 0, the node replies to the sender one cycle later. The count is 1 if the node was never discovered before, otherwise 0, and nothing is forwarded.
- R3: A request that opens a round with a budget h > 0 makes the sender the parent. One cycle later, a request with budget h-1 and the same tag is offered on every other port, and never on the parent port.
- R4: A request whose tag equals the current round's tag is answered one cycle later on the sender's port with count 0. This holds even while the node is waiting for acknowledges.
- R5: While waiting, acknowledges are accepted only from ports still owed one; ready stays low on every other port. Several acknowledges may be taken in the same cycle. One cycle after the last one arrives, a single acknowledge goes to the parent. Its count is the sum of the children's counts plus the node's own contribution, taken modulo 2^CW.
- R6: The node's own contribution is 1 only in the first round that reaches it after reset. The discovered flag then stays set until reset.
- R7: When several ports offer acceptable requests in one cycle, only the lowest-numbered port sees ready, and one request is taken per cycle.
- R8: An outbound acknowledge keeps its valid and count unchanged until taken. While a port's acknowledge slot is full, that port's request ready stays low.
- R9: While waiting, a request with a different tag, or any request from the parent port, is held with ready low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rq_in_valid | input | N | Inbound request valid, one bit per port |
| rq_in_ready | output | N | Inbound request ready, one bit per port |
| rq_in_hop | input | N*HW | Inbound hop budget, port p at bits p*HW +: HW |
| rq_in_round | input | N*RW | Inbound round tag, port p at bits p*RW +: RW |
| rq_out_valid | output | N | Forwarded request valid per port |
| rq_out_ready | input | N | Forwarded request ready per port |
| rq_out_hop | output | HW | Hop budget of the forwarded request, shared by all ports |
| rq_out_round | output | RW | Round tag of the forwarded request, shared by all ports |
| ak_in_valid | input | N | Inbound acknowledge valid per port |
| ak_in_ready | output | N | Inbound acknowledge ready per port |
| ak_in_cnt | input | N*CW | Inbound discovery count, port p at bits p*CW +: CW |
| ak_out_valid | output | N | Outbound acknowledge valid per port |
| ak_out_ready | input | N | Outbound acknowledge ready per port |
| ak_out_cnt | output | N*CW | Outbound discovery count, port p at bits p*CW +: CW |

## Verification
The fan-out path is driven with budgets of 0, 1 and 2. This separates an immediate reply from forwarding and shows that the budget drops by one. Acknowledges arrive one at a time, with a repeat request interleaved, and also several in one cycle. This separates correct summing and completion detection from early or missing replies. A run across rounds, followed by a reset, shows that the own count is added only once and that reset clears it. Simultaneous requests, held outbound slots, wrong-tag requests and acknowledges from the parent port check priority and back-pressure at the ready pins.

// File: rtl/trav_node_pkg.sv
package trav_node_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } node_state_e;
endpackage

// File: rtl/trav_req_pick.sv
module trav_req_pick #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] elig,
  output logic [N-1:0] grant
);
  // lowest-index eligible port wins
  always_comb grant = elig & (~elig + N'(1));

  p_grant_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant) && ((grant & ~elig) == '0));
endmodule

// File: rtl/trav_ack_sum.sv
module trav_ack_sum #(
  parameter int N  = 4,
  parameter int CW = 8
) (
  input  logic [N*CW-1:0] cnt,
  input  logic [N-1:0]    take,
  output logic [CW-1:0]   sum
);
  always_comb begin
    sum = '0;
    for (int p = 0; p < N; p++) begin
      if (take[p]) sum = sum + cnt[p*CW +: CW];
    end
  end
endmodule

// File: rtl/trav_out_slot.sv
module trav_out_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_data,
  output logic         valid,
  input  logic         ready,
  output logic [W-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= load_data;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    valid && !ready |=> valid && $stable(data));
  p_no_overwrite_r8: assert property (@(posedge clk) disable iff (rst)
    valid && !ready |-> !load);
endmodule

// File: rtl/trav_node.sv
module trav_node
  import trav_node_pkg::*;
#(
  parameter int N  = 4,
  parameter int HW = 4,
  parameter int RW = 4,
  parameter int CW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    rq_in_valid,
  output logic [N-1:0]    rq_in_ready,
  input  logic [N*HW-1:0] rq_in_hop,
  input  logic [N*RW-1:0] rq_in_round,
  output logic [N-1:0]    rq_out_valid,
  input  logic [N-1:0]    rq_out_ready,
  output logic [HW-1:0]   rq_out_hop,
  output logic [RW-1:0]   rq_out_round,
  input  logic [N-1:0]    ak_in_valid,
  output logic [N-1:0]    ak_in_ready,
  input  logic [N*CW-1:0] ak_in_cnt,
  output logic [N-1:0]    ak_out_valid,
  input  logic [N-1:0]    ak_out_ready,
  output logic [N*CW-1:0] ak_out_cnt
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  node_state_e      state;
  logic             in_round;
  logic [RW-1:0]    cur_round;
  logic [PW-1:0]    parent;
  logic             discovered;
  logic [N-1:0]     pending;
  logic [CW-1:0]    acc;

  logic [N-1:0]     elig, grant;
  logic             take, new_rnd, do_fwd, ack_now, finish;
  logic [PW-1:0]    sel;
  logic [HW-1:0]    sel_hop;
  logic [RW-1:0]    sel_round;
  logic [N-1:0]     fwd_tgt, ack_take, pend_n;
  logic [CW-1:0]    ack_sum, own, ack_now_cnt, fin_cnt;
  logic [N-1:0]     slot_load;
  logic [CW-1:0]    slot_data [N];

  // which inbound requests may be taken this cycle
  always_comb begin
    for (int p = 0; p < N; p++) begin
      elig[p] = rq_in_valid[p] && !ak_out_valid[p] &&
                ((state == ST_IDLE) ||
                 (in_round && rq_in_round[p*RW +: RW] == cur_round &&
                  parent != PW'(p)));
    end
  end

  trav_req_pick #(.N(N)) pick_i (
    .clk(clk), .rst(rst), .elig(elig), .grant(grant)
  );

  assign rq_in_ready = grant;
  assign take        = |grant;

  always_comb begin
    sel       = '0;
    sel_hop   = '0;
    sel_round = '0;
    for (int p = 0; p < N; p++) begin
      if (grant[p]) begin
        sel       = PW'(p);
        sel_hop   = rq_in_hop[p*HW +: HW];
        sel_round = rq_in_round[p*RW +: RW];
      end
    end
  end

  assign new_rnd     = !(in_round && sel_round == cur_round);
  assign fwd_tgt     = ~grant;
  assign do_fwd      = take && new_rnd && (sel_hop != '0) && (fwd_tgt != '0);
  assign own         = {{(CW-1){1'b0}}, !discovered};
  assign ack_now     = take && !do_fwd;
  assign ack_now_cnt = new_rnd ? own : '0;

  // acknowledge collection
  assign ak_in_ready = pending;
  assign ack_take    = ak_in_valid & pending;
  assign pend_n      = pending & ~ack_take;

  trav_ack_sum #(.N(N), .CW(CW)) sum_i (
    .cnt(ak_in_cnt), .take(ack_take), .sum(ack_sum)
  );

  assign fin_cnt = acc + ack_sum;
  assign finish  = (state == ST_WAIT) && (ack_take != '0) && (pend_n == '0);

  always_comb begin
    for (int p = 0; p < N; p++) begin
      slot_load[p] = (ack_now && grant[p]) || (finish && parent == PW'(p));
      slot_data[p] = (finish && parent == PW'(p)) ? fin_cnt : ack_now_cnt;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_ak_slot
    trav_out_slot #(.W(CW)) slot_i (
      .clk(clk), .rst(rst),
      .load(slot_load[g]), .load_data(slot_data[g]),
      .valid(ak_out_valid[g]), .ready(ak_out_ready[g]),
      .data(ak_out_cnt[g*CW +: CW])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      in_round     <= 1'b0;
      cur_round    <= '0;
      parent       <= '0;
      discovered   <= 1'b0;
      pending      <= '0;
      acc          <= '0;
      rq_out_valid <= '0;
      rq_out_hop   <= '0;
      rq_out_round <= '0;
    end else begin
      rq_out_valid <= (rq_out_valid & ~rq_out_ready) | (do_fwd ? fwd_tgt : '0);
      if (take && new_rnd) begin
        in_round   <= 1'b1;
        cur_round  <= sel_round;
        parent     <= sel;
        discovered <= 1'b1;
      end
      if (do_fwd) begin
        state        <= ST_WAIT;
        pending      <= fwd_tgt;
        acc          <= own;
        rq_out_hop   <= sel_hop - HW'(1);
        rq_out_round <= sel_round;
      end else if (state == ST_WAIT && ack_take != '0) begin
        acc     <= fin_cnt;
        pending <= pend_n;
        if (pend_n == '0) state <= ST_IDLE;
      end
    end
  end

  p_sticky_disc_r6: assert property (@(posedge clk) disable iff (rst)
    discovered |=> discovered);
  p_wait_pending_r5: assert property (@(posedge clk) disable iff (rst)
    state == ST_WAIT |-> pending != '0);
  p_hop_dec_r3: assert property (@(posedge clk) disable iff (rst)
    do_fwd |=> rq_out_hop == $past(sel_hop) - HW'(1));
  p_no_fwd_parent_r3: assert property (@(posedge clk) disable iff (rst)
    state == ST_WAIT |-> !rq_out_valid[parent]);
  p_wait_blocks_new_r9: assert property (@(posedge clk) disable iff (rst)
    state == ST_WAIT && take |-> !new_rnd);
endmodule

// File: tb/trav_node_tb_top.sv
module trav_node_tb_top;
  localparam int N = 4, HW = 4, RW = 4, CW = 8;

  typedef struct packed {
    logic       op;      // 0 request, 1 acknowledge
    logic [1:0] port;
    logic [3:0] rnd;
    logic [3:0] hop;
    logic [7:0] cnt;
    logic [3:0] exp_rq;
    logic [3:0] exp_hop;
    logic [3:0] exp_ak;
    logic [7:0] exp_cnt;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd1, 4'd2, 4'd0, 8'd0, 4'b0000, 4'd0, 4'b0010, 8'd1}, // R2 first reach
    '{1'b0, 2'd2, 4'd2, 4'd0, 8'd0, 4'b0000, 4'd0, 4'b0100, 8'd0}, // R4 repeat
    '{1'b0, 2'd0, 4'd3, 4'd1, 8'd0, 4'b1110, 4'd0, 4'b0000, 8'd0}, // R3 forward
    '{1'b1, 2'd2, 4'd0, 4'd0, 8'd3, 4'b0000, 4'd0, 4'b0000, 8'd0}, // R5 partial
    '{1'b0, 2'd3, 4'd3, 4'd0, 8'd0, 4'b0000, 4'd0, 4'b1000, 8'd0}, // R4 while waiting
    '{1'b1, 2'd1, 4'd0, 4'd0, 8'd2, 4'b0000, 4'd0, 4'b0000, 8'd0}, // R5 partial
    '{1'b1, 2'd3, 4'd0, 4'd0, 8'd0, 4'b0000, 4'd0, 4'b0001, 8'd5}, // R5 R6 sum
    '{1'b0, 2'd0, 4'd4, 4'd2, 8'd0, 4'b1110, 4'd1, 4'b0000, 8'd0}, // R3 hop 2
    '{1'b1, 2'd1, 4'd0, 4'd0, 8'd1, 4'b0000, 4'd0, 4'b0000, 8'd0}, // R5
    '{1'b1, 2'd2, 4'd0, 4'd0, 8'd0, 4'b0000, 4'd0, 4'b0000, 8'd0}, // R5
    '{1'b1, 2'd3, 4'd0, 4'd0, 8'd4, 4'b0000, 4'd0, 4'b0001, 8'd5}, // R5 R6
    '{1'b0, 2'd3, 4'd5, 4'd0, 8'd0, 4'b0000, 4'd0, 4'b1000, 8'd0}  // R2 R6 no own
  };

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N-1:0]    rq_in_valid = '0;
  logic [N-1:0]    rq_in_ready;
  logic [N*HW-1:0] rq_in_hop = '0;
  logic [N*RW-1:0] rq_in_round = '0;
  logic [N-1:0]    rq_out_valid;
  logic [N-1:0]    rq_out_ready = '0;
  logic [HW-1:0]   rq_out_hop;
  logic [RW-1:0]   rq_out_round;
  logic [N-1:0]    ak_in_valid = '0;
  logic [N-1:0]    ak_in_ready;
  logic [N*CW-1:0] ak_in_cnt = '0;
  logic [N-1:0]    ak_out_valid;
  logic [N-1:0]    ak_out_ready = '0;
  logic [N*CW-1:0] ak_out_cnt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  trav_node #(.N(N), .HW(HW), .RW(RW), .CW(CW)) dut_i (
    .clk(clk), .rst(rst),
    .rq_in_valid(rq_in_valid), .rq_in_ready(rq_in_ready),
    .rq_in_hop(rq_in_hop), .rq_in_round(rq_in_round),
    .rq_out_valid(rq_out_valid), .rq_out_ready(rq_out_ready),
    .rq_out_hop(rq_out_hop), .rq_out_round(rq_out_round),
    .ak_in_valid(ak_in_valid), .ak_in_ready(ak_in_ready), .ak_in_cnt(ak_in_cnt),
    .ak_out_valid(ak_out_valid), .ak_out_ready(ak_out_ready), .ak_out_cnt(ak_out_cnt)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] cnt_at(input int p);
    return ak_out_cnt[p*CW +: CW];
  endfunction

  task automatic push_req(input int p, input logic [3:0] r, input logic [3:0] h);
    int w;
    @(negedge clk);
    rq_in_valid[p] = 1'b1;
    rq_in_hop[p*HW +: HW] = h;
    rq_in_round[p*RW +: RW] = r;
    #1;
    w = 0;
    while (!rq_in_ready[p] && w < 16) begin
      @(negedge clk); #1; w++;
    end
    chk(rq_in_ready[p], "R7 request ready", 32'(rq_in_ready), 32'(1 << p));
    @(posedge clk);
    @(negedge clk);
    rq_in_valid[p] = 1'b0;
    #1;
  endtask

  task automatic push_ack(input int p, input logic [7:0] c);
    int w;
    @(negedge clk);
    ak_in_valid[p] = 1'b1;
    ak_in_cnt[p*CW +: CW] = c;
    #1;
    w = 0;
    while (!ak_in_ready[p] && w < 16) begin
      @(negedge clk); #1; w++;
    end
    chk(ak_in_ready[p], "R5 ack ready", 32'(ak_in_ready), 32'(1 << p));
    @(posedge clk);
    @(negedge clk);
    ak_in_valid[p] = 1'b0;
    #1;
  endtask

  task automatic drain();
    @(negedge clk);
    rq_out_ready = '1;
    ak_out_ready = '1;
    @(negedge clk);
    rq_out_ready = '0;
    ak_out_ready = '0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(rq_out_valid == '0 && ak_out_valid == '0, "R1 reset outputs",
        32'({rq_out_valid, ak_out_valid}), 32'd0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].op == 1'b0) push_req(int'(VEC[i].port), VEC[i].rnd, VEC[i].hop);
      else                   push_ack(int'(VEC[i].port), VEC[i].cnt);
      chk(rq_out_valid == VEC[i].exp_rq, "R3 forward mask", 32'(rq_out_valid), 32'(VEC[i].exp_rq));
      if (VEC[i].exp_rq != '0)
        chk(rq_out_hop == VEC[i].exp_hop && rq_out_round == VEC[i].rnd, "R3 forward hop/tag",
            32'({rq_out_round, rq_out_hop}), 32'({VEC[i].rnd, VEC[i].exp_hop}));
      chk(ak_out_valid == VEC[i].exp_ak, "R5 ack mask", 32'(ak_out_valid), 32'(VEC[i].exp_ak));
      for (int p = 0; p < N; p++)
        if (VEC[i].exp_ak[p])
          chk(cnt_at(p) == VEC[i].exp_cnt, "R2 R5 ack count", 32'(cnt_at(p)), 32'(VEC[i].exp_cnt));
      drain();
    end

    // R1: reset clears discovered flag and round membership
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; #1;
    chk(rq_out_valid == '0 && ak_out_valid == '0 && ak_in_ready == '0, "R1 reset state",
        32'({rq_out_valid, ak_out_valid, ak_in_ready}), 32'd0);
    push_req(2, 4'd5, 4'd3);
    chk(rq_out_valid == 4'b1011 && rq_out_hop == 4'd2 && rq_out_round == 4'd5, "R1 R3 new round after reset",
        32'({rq_out_valid, rq_out_round, rq_out_hop}), 32'({4'b1011, 4'd5, 4'd2}));
    drain();

    // R5 R9: ack from parent and request with another tag are refused while waiting
    @(negedge clk);
    ak_in_valid[2] = 1'b1; ak_in_cnt[2*CW +: CW] = 8'd9;
    rq_in_valid[0] = 1'b1; rq_in_round[0 +: RW] = 4'd9; rq_in_hop[0 +: HW] = 4'd0;
    #1;
    chk(ak_in_ready[2] == 1'b0, "R5 non-pending ack refused", 32'(ak_in_ready), 32'b1011);
    chk(rq_in_ready == '0, "R9 other tag held while waiting", 32'(rq_in_ready), 32'd0);
    @(negedge clk);
    ak_in_valid[2] = 1'b0; rq_in_valid[0] = 1'b0;
    #1;
    chk(ak_out_valid == '0, "R9 no reply while held", 32'(ak_out_valid), 32'd0);

    // R5 R6: three acks in one cycle, own count 1 after reset
    @(negedge clk);
    ak_in_valid = 4'b1011;
    ak_in_cnt = {8'd1, 8'd0, 8'd1, 8'd1};
    @(negedge clk);
    ak_in_valid = '0;
    #1;
    chk(ak_out_valid == 4'b0100 && cnt_at(2) == 8'd4, "R5 R6 merged ack",
        32'({ak_out_valid, cnt_at(2)}), 32'({4'b0100, 8'd4}));
    drain();

    // R7 priority, then R4 for the loser
    @(negedge clk);
    rq_in_valid = 4'b1010;
    rq_in_round = {4'd6, 4'd0, 4'd6, 4'd0};
    rq_in_hop = '0;
    #1;
    chk(rq_in_ready == 4'b0010, "R7 lowest port wins", 32'(rq_in_ready), 32'b0010);
    @(negedge clk);
    rq_in_valid[1] = 1'b0;
    #1;
    chk(ak_out_valid == 4'b0010 && cnt_at(1) == 8'd0, "R7 R6 winner reply",
        32'({ak_out_valid, cnt_at(1)}), 32'({4'b0010, 8'd0}));
    chk(rq_in_ready == 4'b1000, "R7 next request taken", 32'(rq_in_ready), 32'b1000);
    @(negedge clk);
    rq_in_valid = '0;
    #1;
    chk(ak_out_valid == 4'b1010 && cnt_at(3) == 8'd0, "R4 same-round reply",
        32'({ak_out_valid, cnt_at(3)}), 32'({4'b1010, 8'd0}));

    // R8: replies held under back-pressure, port with full slot refused
    repeat (3) @(negedge clk);
    #1;
    chk(ak_out_valid == 4'b1010 && cnt_at(1) == 8'd0, "R8 reply held",
        32'(ak_out_valid), 32'b1010);
    rq_in_valid[1] = 1'b1; rq_in_round[1*RW +: RW] = 4'd6;
    #1;
    chk(rq_in_ready[1] == 1'b0, "R8 full slot blocks request", 32'(rq_in_ready), 32'd0);
    rq_in_valid[1] = 1'b0;
    drain();
    push_req(1, 4'd6, 4'd0);
    chk(ak_out_valid == 4'b0010 && cnt_at(1) == 8'd0, "R8 R4 accepted after drain",
        32'({ak_out_valid, cnt_at(1)}), 32'({4'b0010, 8'd0}));
    drain();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule